// File: doc/BRIEF.md
# Nested Interrupt Priority Level Tracker

This block keeps the priority of the interrupt level the processor is currently running and decides whether a new request may interrupt it. An arbiter outside the block supplies the priority of the strongest pending request. The block raises the active-low processor interrupt line only when that priority is strictly above the running level. Level 0 stands for background code.

When the processor acknowledges an interrupt, the running level is saved on a hardware LIFO and the request's priority becomes the new running level. When a handler signals that it has finished, the saved level is taken back from the LIFO. Handlers can therefore nest without software bookkeeping. A force strobe lets software load the running level directly, for example to mask requests for a critical section. An exit that arrives with nothing saved drops to background and latches a sticky underflow indication.

Top module: `prio_level_stack`

## Requirements
- R1: After reset, `act_lvl` is 0, `irq_n` is 1, `underflow` is 0, and the LIFO is empty.
- R2: `irq_n` is registered. In the cycle after a clock edge at which `ack` was low, `irq_n` is 0 if `win_prio` was strictly greater than `act_lvl` at that edge, and 1 otherwise.
- R3: An acknowledge (`ack` high, `exit_req` low, `force_en` low, LIFO not full) pushes the current `act_lvl` onto the LIFO and loads `win_prio` into `act_lvl` on the next edge.
- R4: An exit (`exit_req` high, `ack` low, `force_en` low) with a non-empty LIFO restores `act_lvl` to the most recently pushed level and removes that entry.
- R5: An exit with an empty LIFO sets `act_lvl` to 0 and sets `underflow`. `underflow` stays 1 until reset.
- R6: `force_en` high loads `force_lvl` into `act_lvl` and leaves the LIFO untouched. In that cycle, `ack` and `exit_req` have no effect on the level or the LIFO.
- R7: In the cycle after any edge at which `ack` was high, `irq_n` is 1.
- R8: When `ack` and `exit_req` are high together with `force_en` low and the LIFO not full, the acknowledge is applied first and the exit then undoes it. `act_lvl`, the LIFO and `underflow` all stay unchanged.
- R9: The LIFO holds 16 levels. An `ack` that arrives while 16 levels are stored is ignored, as if `ack` were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_prio | input | 4 | Priority of the strongest pending request, from the arbiter |
| ack | input | 1 | Processor acknowledge pulse |
| exit_req | input | 1 | Handler-finished pulse |
| force_en | input | 1 | Load `force_lvl` into the running level |
| force_lvl | input | 4 | Level loaded by `force_en` |
| act_lvl | output | 4 | Current running priority level |
| irq_n | output | 1 | Active-low interrupt request to the processor |
| underflow | output | 1 | Sticky flag: an exit arrived with an empty LIFO |

## Verification
The collision of interest is an acknowledge and an exit in the same cycle. This collision is also checked against the LIFO-full condition and against a simultaneous force. Random stimulus raises `ack` and `exit_req` independently, so coincident pulses occur often and at many LIFO depths. Directed sequences add the case of a full LIFO and the case of a force arriving alongside both pulses. A bench model resolves each cycle in the stated order: force first, then the acknowledge if the LIFO has room, then the exit. Every cycle, the model's level, interrupt line and underflow flag are compared with the ports. A LIFO corrupted by a wrong ordering shows up on later exits as a wrong restored level.

// File: rtl/prio_stack_pkg.sv
// Package: shared widths and types for the priority level tracker.
// Assumes levels are unsigned and that a larger value outranks a smaller one.
package prio_stack_pkg;
    localparam int LVL_W = 4;
    localparam int DEPTH = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;

    // Operation chosen for the LIFO in a cycle.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/level_lifo.sv
// Module: level_lifo
// Hardware LIFO of saved priority levels. Each entry is its own register,
// built in a generate loop. A push while full and a pop while empty must
// not be requested; the caller guarantees this.
module level_lifo #(
    parameter int LVL_W = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] wr_lvl,
    output logic [LVL_W-1:0] top_lvl,
    output logic             empty,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LVL_W-1:0] ent_q [DEPTH];
    logic [CNT_W-1:0] rd_cnt;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign rd_cnt = cnt_q - CNT_W'(1);
    assign top_lvl = ent_q[rd_cnt[IDX_W-1:0]];

    // Occupancy counter: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // One register per slot, written when the push targets that slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (push && !full && (cnt_q == CNT_W'(i))) begin
                ent_q[i] <= wr_lvl;
            end
        end
    end

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/irq_gate.sv
// Module: irq_gate
// Registered greater-than comparator that drives the active-low interrupt
// line. The line is held inactive for the cycle that follows an acknowledge.
module irq_gate #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic [LVL_W-1:0] run_lvl,
    input  logic             ack,
    output logic             irq_n
);
    logic outranks;

    assign outranks = (req_lvl > run_lvl);

    // Register the request line; an acknowledge suppresses it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ack ? 1'b1 : !outranks;
        end
    end

    assert_quiet_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> irq_n);
    assert_no_req_at_or_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lvl <= run_lvl) |=> irq_n);
endmodule

// File: rtl/prio_level_stack.sv
// Module: prio_level_stack (top)
// Tracks the running interrupt priority level. The running level is saved on
// an acknowledge and restored on an exit. The processor request is driven
// through irq_gate. Precedence in a cycle: force, then acknowledge (only if
// the LIFO has room), then exit.
// Assumes ack, exit_req and force_en are single-cycle pulses from the core.
module prio_level_stack
    import prio_stack_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int SD = 1 << LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] win_prio,
    input  logic          ack,
    input  logic          exit_req,
    input  logic          force_en,
    input  logic [LW-1:0] force_lvl,
    output logic [LW-1:0] act_lvl,
    output logic          irq_n,
    output logic          underflow
);
    logic          lifo_empty;
    logic          lifo_full;
    logic [LW-1:0] lifo_top;
    logic          ack_ok;
    stk_op_e       op;
    logic [LW-1:0] lvl_d;
    logic          uf_set;
    logic          do_push;
    logic          do_pop;

    // An acknowledge only counts when a slot is free.
    assign ack_ok  = ack && !lifo_full;
    assign do_push = (op == OP_PUSH);
    assign do_pop  = (op == OP_POP);

    // Resolve this cycle's operation and next level by precedence.
    always_comb begin
        op     = OP_HOLD;
        lvl_d  = act_lvl;
        uf_set = 1'b0;
        if (force_en) begin
            lvl_d = force_lvl;
        end else if (ack_ok && exit_req) begin
            lvl_d = act_lvl;
        end else if (ack_ok) begin
            op    = OP_PUSH;
            lvl_d = win_prio;
        end else if (exit_req) begin
            if (lifo_empty) begin
                lvl_d  = '0;
                uf_set = 1'b1;
            end else begin
                op    = OP_POP;
                lvl_d = lifo_top;
            end
        end
    end

    // Running level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lvl <= '0;
        end else begin
            act_lvl <= lvl_d;
        end
    end

    // Sticky underflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (uf_set) begin
            underflow <= 1'b1;
        end
    end

    level_lifo #(.LVL_W(LW), .DEPTH(SD)) u_lifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (do_push),
        .pop    (do_pop),
        .wr_lvl (act_lvl),
        .top_lvl(lifo_top),
        .empty  (lifo_empty),
        .full   (lifo_full)
    );

    irq_gate #(.LVL_W(LW)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_lvl(win_prio),
        .run_lvl(act_lvl),
        .ack    (ack),
        .irq_n  (irq_n)
    );

    assert_ack_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !exit_req && !force_en && !lifo_full) |=> (act_lvl == $past(win_prio)));
    assert_exit_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req && !ack && !force_en && lifo_empty) |=> (act_lvl == '0 && underflow));
    assert_underflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    assert_force_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_en |=> (act_lvl == $past(force_lvl)));
    assert_collide_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && exit_req && !force_en && !lifo_full) |=> $stable(act_lvl));
endmodule

// File: tb/prio_level_stack_bench.sv
// Bench: seeded random pulses plus directed corners, checked every cycle
// against a behavioural model held in bench functions.
module prio_level_stack_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] win_prio = '0;
    logic       ack = 1'b0;
    logic       exit_req = 1'b0;
    logic       force_en = 1'b0;
    logic [3:0] force_lvl = '0;
    logic [3:0] act_lvl;
    logic       irq_n;
    logic       underflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state.
    logic [3:0] m_lvl = '0;
    logic [3:0] m_stk [16];
    int         m_cnt = 0;
    logic       m_uf  = 1'b0;
    logic       m_irq_n = 1'b1;
    string      m_tag = "R1";

    always #4 clk = ~clk;

    prio_level_stack u_prio_level_stack (
        .clk(clk), .rst_n(rst_n), .win_prio(win_prio), .ack(ack),
        .exit_req(exit_req), .force_en(force_en), .force_lvl(force_lvl),
        .act_lvl(act_lvl), .irq_n(irq_n), .underflow(underflow)
    );

    function automatic logic exp_irq_n(logic a, logic [3:0] w, logic [3:0] l);
        return a ? 1'b1 : !(w > l);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the inputs currently driven.
    task automatic model_edge();
        bit ok_ack;
        m_irq_n = exp_irq_n(ack, win_prio, m_lvl);
        ok_ack  = ack && (m_cnt < 16);
        if (force_en) begin
            m_lvl = force_lvl; m_tag = "R6";
        end else if (ok_ack && exit_req) begin
            m_tag = "R8";
        end else if (ok_ack) begin
            m_stk[m_cnt] = m_lvl; m_cnt++; m_lvl = win_prio; m_tag = "R3";
        end else if (exit_req) begin
            if (m_cnt == 0) begin
                m_lvl = '0; m_uf = 1'b1; m_tag = "R5";
            end else begin
                m_cnt--; m_lvl = m_stk[m_cnt]; m_tag = "R4";
            end
        end else if (ack) begin
            m_tag = "R9";
        end else begin
            m_tag = "R2";
        end
    endtask

    // Drive one cycle of inputs, step the edge, and compare at the next negedge.
    task automatic cyc(logic [3:0] w, logic a, logic e, logic f, logic [3:0] fl);
        win_prio = w; ack = a; exit_req = e; force_en = f; force_lvl = fl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({m_tag, " level"}, act_lvl, m_lvl);
        chk(ack ? "R7 irq_n" : "R2 irq_n", irq_n, m_irq_n);
        chk("R5 underflow", underflow, m_uf);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 level", act_lvl, 0);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 underflow", underflow, 0);

        // R2: request above background shows up one cycle later.
        cyc(4'd5, 0, 0, 0, 0);
        // R3 then R7: acknowledge loads 5, line quiet.
        cyc(4'd5, 1, 0, 0, 0);
        // R2: equal priority does not request.
        cyc(4'd5, 0, 0, 0, 0);
        cyc(4'd9, 1, 0, 0, 0);
        // R8: collision keeps level 9.
        cyc(4'd12, 1, 1, 0, 0);
        // R4: nested restores 5 then 0.
        cyc(4'd0, 0, 1, 0, 0);
        cyc(4'd0, 0, 1, 0, 0);
        // R6: force with both pulses present.
        cyc(4'd15, 1, 1, 1, 4'd3);
        // R9: fill LIFO with 16 acknowledges, then one more is ignored.
        cyc(4'd0, 0, 0, 1, 4'd0);
        for (int i = 0; i < 16; i++) cyc(4'(i + 1), 1, 0, 0, 0);
        cyc(4'd2, 1, 0, 0, 0);
        // R9 with exit: full LIFO, so the exit alone acts.
        cyc(4'd2, 1, 1, 0, 0);
        for (int i = 0; i < 15; i++) cyc(4'd0, 0, 1, 0, 0);
        // R5: underflow, then sticky.
        cyc(4'd0, 0, 1, 0, 0);
        cyc(4'd7, 0, 0, 0, 0);

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] w, fl;
            logic a, e, f;
            w  = 4'($urandom_range(0, 15));
            fl = 4'($urandom_range(0, 15));
            a  = ($urandom_range(0, 3) == 0);
            e  = ($urandom_range(0, 3) == 0);
            f  = ($urandom_range(0, 29) == 0);
            cyc(w, a, e, f, fl);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule